// File: doc/BRIEF.md
# Hardware Breakpoint Debug Unit

This block watches the processor's instruction fetches and data accesses and raises a debug trap when one of them touches an address that software has armed as a hardware breakpoint. Four breakpoint slots each hold an address. A shared control word sets, for each slot, whether it is armed, which access kind it reacts to (instruction fetch, data write, or any data read or write) and how many bytes it covers (1, 2 or 4, aligned to that size). A status word records which slots fired. Its bits stay set until software writes new values into it.

Software reaches the eight debug registers through a single-cycle register port with indices 0 to 7. Indices 0 to 3 are the address slots, 6 is status and 7 is control. Indices 4 and 5 depend on an extension-enable input. When that input is low they are aliases of 6 and 7. When it is high, any access to them is refused with a fault and has no effect. The access monitor port carries an address, a size code, a kind code and a valid bit. The trap output pulses one cycle after a matching access.

Top module: `hwbp_unit`

## Requirements
- R1: Indices 0 to 3 each hold a full-width breakpoint address that is written when `reg_req` and `reg_wr` are high and is read back combinationally on `reg_rdata` when `reg_req` is high and `reg_wr` is low.
- R2: When `ext_en` is 1, a request to index 4 or 5 drives `reg_fault` high in the same cycle, returns 0 on `reg_rdata` and changes no register. `reg_fault` is never high without such a request.
- R3: When `ext_en` is 0, index 4 reads and writes the status register (index 6) and index 5 reads and writes the control register (index 7).
- R4: Control word layout, for slot k = 0..3:
  - bits [2k+1:2k] are two enable bits; the slot is armed if either bit is 1;
  - bits [17+4k:16+4k] are the type: 00 = execute, 01 = write, 11 = read or write, 10 = never matches;
  - bits [19+4k:18+4k] are the length: 00 = 1 byte, 01 = 2 bytes, 11 or 10 = 4 bytes.
- R5: Access kind on `mon_kind`: 00 = fetch, 01 = write, 10 = read, 11 = none. An execute slot matches only fetches. A write slot matches only writes. A read-or-write slot matches reads and writes.
- R6: A slot's watched range starts at its address rounded down to its length. An access covers `mon_addr` up to `mon_addr` + size - 1, where `mon_size` is 00 = 1 byte, 01 = 2 bytes, 11 or 10 = 4 bytes. A slot matches when the two ranges overlap.
- R7: Status bits [3:0] are set, at the clock edge that ends the access, for every slot that matched. Upper status bits read 0. The bits hold until software writes index 6. If a software write and a match fall in the same cycle, the written value is taken and the matched bits are set on top of it.
- R8: `trap_o` is high for exactly the one cycle after each clock edge that ends a matching access. It changes at the same edge as the status bits.
- R9: A slot whose two enable bits are both 0 never sets a status bit or raises the trap.
- R10: After reset, every register reads 0 and `trap_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Extension enable: 1 makes indices 4 and 5 fault |
| reg_req | input | 1 | Register port request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Register index 0 to 7 |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data (combinational) |
| reg_fault | output | 1 | Access exception for a refused index |
| mon_valid | input | 1 | Monitored access present this cycle |
| mon_addr | input | ADDR_W | Byte address of the access |
| mon_size | input | 2 | Access size code |
| mon_kind | input | 2 | Access kind code |
| trap_o | output | 1 | Debug trap pulse |

## Verification
A software write to the status register and a breakpoint match can land on the same clock edge. The bench provokes this by presenting a status-clearing write and a fetch that hits an armed execute slot in one cycle. It then requires that the matched bit survives the clear and that the trap still pulses. A second collision happens when one access hits two armed slots at once. The bench judges that case by checking that both status bits are set and that only a single trap pulse appears.

// File: rtl/hwbp_pkg.sv
package hwbp_pkg;

  localparam int NUM_BP = 4;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    BP_EXEC  = 2'b00,
    BP_WRITE = 2'b01,
    BP_RSVD  = 2'b10,
    BP_RDWR  = 2'b11
  } bp_type_e;

  // Byte span for a length / size code: 00 -> 1, 01 -> 2, others -> 4.
  function automatic logic [2:0] span_bytes(input logic [1:0] code);
    case (code)
      2'b00:   span_bytes = 3'd1;
      2'b01:   span_bytes = 3'd2;
      default: span_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/hwbp_cmp.sv
module hwbp_cmp
  import hwbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        en_bits,
  input  logic [1:0]        bp_type,
  input  logic [1:0]        bp_len,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [1:0]        mon_size,
  input  logic [1:0]        mon_kind,
  output logic              hit
);

  localparam int XW = ADDR_W + 1;

  logic              kind_ok;
  logic [2:0]        bp_span;
  logic [2:0]        acc_span;
  logic [ADDR_W-1:0] bp_mask;
  logic [XW-1:0]     b_lo, b_hi, a_lo, a_hi;

  always_comb begin
    case (bp_type_e'(bp_type))
      BP_EXEC:  kind_ok = (acc_kind_e'(mon_kind) == ACC_FETCH);
      BP_WRITE: kind_ok = (acc_kind_e'(mon_kind) == ACC_WRITE);
      BP_RDWR:  kind_ok = (acc_kind_e'(mon_kind) == ACC_WRITE) ||
                          (acc_kind_e'(mon_kind) == ACC_READ);
      default:  kind_ok = 1'b0;
    endcase
  end

  always_comb begin
    bp_span  = span_bytes(bp_len);
    acc_span = span_bytes(mon_size);
    bp_mask  = ~ADDR_W'(bp_span - 3'd1);
    b_lo     = {1'b0, bp_addr & bp_mask};
    b_hi     = b_lo + XW'(bp_span) - XW'(1);
    a_lo     = {1'b0, mon_addr};
    a_hi     = a_lo + XW'(acc_span) - XW'(1);
    hit      = mon_valid && (|en_bits) && kind_ok &&
               (a_lo <= b_hi) && (b_lo <= a_hi);
  end

endmodule

// File: rtl/hwbp_regs.sv
module hwbp_regs
  import hwbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_en,
  input  logic                     reg_req,
  input  logic                     reg_wr,
  input  logic [2:0]               reg_idx,
  input  logic [ADDR_W-1:0]        reg_wdata,
  output logic [ADDR_W-1:0]        reg_rdata,
  output logic                     reg_fault,
  input  logic [NUM_BP-1:0]        hit_vec,
  output logic [NUM_BP*ADDR_W-1:0] bp_addr_flat,
  output logic [ADDR_W-1:0]        ctl_q,
  output logic [NUM_BP-1:0]        status_q
);

  logic [ADDR_W-1:0] addr_q [NUM_BP];
  logic [2:0]        eff_idx;
  logic              wr_ok;
  logic [NUM_BP-1:0] addr_we;
  logic              ctl_we;
  logic [NUM_BP-1:0] status_d;

  // Index decode with aliasing / refusal of the two extension slots.
  always_comb begin
    reg_fault = reg_req && ext_en && (reg_idx == 3'd4 || reg_idx == 3'd5);
    eff_idx   = reg_idx;
    if (!ext_en && reg_idx == 3'd4) eff_idx = 3'd6;
    if (!ext_en && reg_idx == 3'd5) eff_idx = 3'd7;
    wr_ok     = reg_req && reg_wr && !reg_fault;
  end

  // Next-state logic.
  always_comb begin
    for (int k = 0; k < NUM_BP; k++) begin
      addr_we[k] = wr_ok && (eff_idx == 3'(k));
    end
    ctl_we   = wr_ok && (eff_idx == 3'd7);
    status_d = status_q;
    if (wr_ok && eff_idx == 3'd6) status_d = reg_wdata[NUM_BP-1:0];
    status_d = status_d | hit_vec;
  end

  // Read mux.
  always_comb begin
    reg_rdata = '0;
    if (reg_req && !reg_wr && !reg_fault) begin
      case (eff_idx)
        3'd6:    reg_rdata = ADDR_W'(status_q);
        3'd7:    reg_rdata = ctl_q;
        default: reg_rdata = addr_q[eff_idx[1:0]];
      endcase
    end
  end

  generate
    for (genvar k = 0; k < NUM_BP; k++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          addr_q[k] <= '0;
        else if (addr_we[k]) addr_q[k] <= reg_wdata;
      end
      assign bp_addr_flat[k*ADDR_W +: ADDR_W] = addr_q[k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

endmodule

// File: rtl/hwbp_unit.sv
module hwbp_unit
  import hwbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [2:0]        reg_idx,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              reg_fault,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [1:0]        mon_size,
  input  logic [1:0]        mon_kind,
  output logic              trap_o
);

  localparam int EN_BASE  = 0;
  localparam int CFG_BASE = 16;

  logic [NUM_BP*ADDR_W-1:0] bp_addr_flat;
  logic [ADDR_W-1:0]        ctl_q;
  logic [NUM_BP-1:0]        status_q;
  logic [NUM_BP-1:0]        hit_vec;
  logic                     trap_d;
  logic                     trap_q;

  hwbp_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_en       (ext_en),
    .reg_req      (reg_req),
    .reg_wr       (reg_wr),
    .reg_idx      (reg_idx),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .reg_fault    (reg_fault),
    .hit_vec      (hit_vec),
    .bp_addr_flat (bp_addr_flat),
    .ctl_q        (ctl_q),
    .status_q     (status_q)
  );

  generate
    for (genvar k = 0; k < NUM_BP; k++) begin : g_cmp
      hwbp_cmp #(.ADDR_W(ADDR_W)) cmp_i (
        .en_bits   (ctl_q[EN_BASE + 2*k +: 2]),
        .bp_type   (ctl_q[CFG_BASE + 4*k +: 2]),
        .bp_len    (ctl_q[CFG_BASE + 4*k + 2 +: 2]),
        .bp_addr   (bp_addr_flat[k*ADDR_W +: ADDR_W]),
        .mon_valid (mon_valid),
        .mon_addr  (mon_addr),
        .mon_size  (mon_size),
        .mon_kind  (mon_kind),
        .hit       (hit_vec[k])
      );
    end
  endgenerate

  always_comb trap_d = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign trap_o = trap_q;

endmodule

// File: rtl/hwbp_chk.sv
module hwbp_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_en,
  input logic              reg_req,
  input logic              reg_wr,
  input logic [2:0]        reg_idx,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic              reg_fault,
  input logic              mon_valid,
  input logic              trap_o,
  input logic [ADDR_W-1:0] ctl_q,
  input logic [3:0]        status_q
);

  logic ext_slot;
  logic st_write;

  always_comb begin
    ext_slot = (reg_idx == 3'd4) || (reg_idx == 3'd5);
    st_write = reg_req && reg_wr && !reg_fault &&
               ((reg_idx == 3'd6) || (reg_idx == 3'd4 && !ext_en));
  end

  // R2
  fault_when_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && ext_en && ext_slot) |-> reg_fault);

  // R2
  fault_only_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_fault |-> (reg_req && ext_en && ext_slot));

  // R2
  refused_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_fault && reg_wr) |=> $stable(ctl_q));

  // R3
  ctl_alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_wr && !ext_en && reg_idx == 3'd5) |-> (reg_rdata == ctl_q));

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_write |=> (($past(status_q) & ~status_q) == 4'd0));

  // R8
  trap_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(mon_valid) && status_q != 4'd0));

  // R9
  trap_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(ctl_q[7:0]) != 8'd0));

endmodule

bind hwbp_unit hwbp_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_en    (ext_en),
  .reg_req   (reg_req),
  .reg_wr    (reg_wr),
  .reg_idx   (reg_idx),
  .reg_rdata (reg_rdata),
  .reg_fault (reg_fault),
  .mon_valid (mon_valid),
  .trap_o    (trap_o),
  .ctl_q     (ctl_q),
  .status_q  (status_q)
);

// File: tb/hwbp_unit_tb_top.sv
`timescale 1ns/1ps
module hwbp_unit_tb_top;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_en = 1'b0;
  logic          reg_req = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_idx = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          reg_fault;
  logic          mon_valid = 1'b0;
  logic [AW-1:0] mon_addr = '0;
  logic [1:0]    mon_size = '0;
  logic [1:0]    mon_kind = 2'b11;
  logic          trap_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  hwbp_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_fault(reg_fault),
    .mon_valid(mon_valid), .mon_addr(mon_addr), .mon_size(mon_size),
    .mon_kind(mon_kind), .trap_o(trap_o)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Slot config word per the control layout of R4.
  function automatic logic [AW-1:0] slot_cfg(input int k, input logic [1:0] en,
                                            input logic [1:0] typ, input logic [1:0] len);
    logic [AW-1:0] v;
    v = '0;
    v[2*k +: 2]      = en;
    v[16 + 4*k +: 2] = typ;
    v[18 + 4*k +: 2] = len;
    return v;
  endfunction

  task automatic reg_write(input logic [2:0] idx, input logic [AW-1:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] idx, output logic [AW-1:0] d, output logic f);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b0; reg_idx = idx;
    #1;
    d = reg_rdata; f = reg_fault;
    @(negedge clk);
    reg_req = 1'b0;
  endtask

  // One access; returns trap level after the ending edge and one cycle later.
  task automatic access(input logic [AW-1:0] a, input logic [1:0] sz, input logic [1:0] kd,
                        output logic t0, output logic t1);
    @(negedge clk);
    mon_valid = 1'b1; mon_addr = a; mon_size = sz; mon_kind = kd;
    @(posedge clk);
    @(negedge clk);
    mon_valid = 1'b0; mon_kind = 2'b11;
    t0 = trap_o;
    @(negedge clk);
    t1 = trap_o;
  endtask

  task automatic expect_access(input string req, input logic [AW-1:0] a, input logic [1:0] sz,
                               input logic [1:0] kd, input logic exp_trap, input logic [3:0] exp_st);
    logic t0, t1, f;
    logic [AW-1:0] d;
    reg_write(3'd6, '0);
    access(a, sz, kd, t0, t1);
    check({req, " trap"}, AW'(t0), AW'(exp_trap));
    check({req, " trap one cycle"}, AW'(t1), '0);
    reg_read(3'd6, d, f);
    check({req, " status"}, d, AW'(exp_st));
  endtask

  task automatic t_reset();
    logic [AW-1:0] d; logic f;
    for (int i = 0; i < 8; i++) begin
      reg_read(3'(i), d, f);
      check("R10 reset reg", d, '0);
    end
    check("R10 reset trap", AW'(trap_o), '0);
  endtask

  task automatic t_addr_regs();
    logic [AW-1:0] d; logic f;
    for (int i = 0; i < 4; i++) reg_write(3'(i), 32'hA5A5_0000 + AW'(i * 17));
    for (int i = 0; i < 4; i++) begin
      reg_read(3'(i), d, f);
      check("R1 addr readback", d, 32'hA5A5_0000 + AW'(i * 17));
    end
  endtask

  task automatic t_alias();
    logic [AW-1:0] d; logic f;
    ext_en = 1'b0;
    reg_write(3'd5, 32'h0000_0000);
    reg_write(3'd5, 32'h00F0_0000);
    reg_read(3'd7, d, f);
    check("R3 idx5 writes ctl", d, 32'h00F0_0000);
    reg_write(3'd4, 32'h0000_000B);
    reg_read(3'd6, d, f);
    check("R3 idx4 writes status", d, 32'h0000_000B);
    reg_read(3'd4, d, f);
    check("R3 idx4 reads status", d, 32'h0000_000B);
    reg_read(3'd5, d, f);
    check("R3 idx5 reads ctl", d, 32'h00F0_0000);
    reg_write(3'd7, '0);
    reg_write(3'd6, '0);
  endtask

  task automatic t_refused();
    logic [AW-1:0] d; logic f;
    ext_en = 1'b1;
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_idx = 3'd5; reg_wdata = 32'hFFFF_FFFF;
    #1;
    check("R2 fault on write idx5", AW'(reg_fault), 32'd1);
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
    reg_write(3'd4, 32'hF);
    reg_read(3'd4, d, f);
    check("R2 fault on read idx4", AW'(f), 32'd1);
    check("R2 refused read data", d, '0);
    reg_read(3'd7, d, f);
    check("R2 ctl untouched", d, '0);
    check("R2 no fault idx7", AW'(f), '0);
    reg_read(3'd6, d, f);
    check("R2 status untouched", d, '0);
    ext_en = 1'b0;
  endtask

  task automatic t_exec();
    reg_write(3'd0, 32'h0000_1000);
    reg_write(3'd7, slot_cfg(0, 2'b01, 2'b00, 2'b00));
    expect_access("R5 exec fetch hit", 32'h1000, 2'b00, 2'b00, 1'b1, 4'h1);
    expect_access("R5 exec ignores write", 32'h1000, 2'b00, 2'b01, 1'b0, 4'h0);
    expect_access("R5 exec ignores read", 32'h1000, 2'b00, 2'b10, 1'b0, 4'h0);
    expect_access("R6 exec next byte miss", 32'h1001, 2'b00, 2'b00, 1'b0, 4'h0);
  endtask

  task automatic t_write_len2();
    reg_write(3'd1, 32'h0000_2001);
    reg_write(3'd7, slot_cfg(1, 2'b01, 2'b01, 2'b01));
    expect_access("R6 len2 overlap from below", 32'h1FFF, 2'b01, 2'b01, 1'b1, 4'h2);
    expect_access("R6 len2 aligned low byte", 32'h2000, 2'b00, 2'b01, 1'b1, 4'h2);
    expect_access("R6 len2 past end", 32'h2002, 2'b00, 2'b01, 1'b0, 4'h0);
    expect_access("R5 write slot ignores read", 32'h2000, 2'b00, 2'b10, 1'b0, 4'h0);
  endtask

  task automatic t_rdwr_len4();
    reg_write(3'd2, 32'h0000_3006);
    reg_write(3'd7, slot_cfg(2, 2'b10, 2'b11, 2'b11));
    expect_access("R5 rdwr read hit", 32'h3007, 2'b00, 2'b10, 1'b1, 4'h4);
    expect_access("R6 len4 word overlap", 32'h3002, 2'b11, 2'b01, 1'b1, 4'h4);
    expect_access("R5 rdwr ignores fetch", 32'h3004, 2'b11, 2'b00, 1'b0, 4'h0);
    expect_access("R6 len4 past end", 32'h3008, 2'b00, 2'b10, 1'b0, 4'h0);
    expect_access("R5 kind none ignored", 32'h3004, 2'b00, 2'b11, 1'b0, 4'h0);
  endtask

  task automatic t_disabled();
    reg_write(3'd3, 32'h0000_4000);
    reg_write(3'd7, slot_cfg(3, 2'b00, 2'b11, 2'b11));
    expect_access("R9 disarmed slot", 32'h4000, 2'b11, 2'b10, 1'b0, 4'h0);
    reg_write(3'd7, slot_cfg(3, 2'b00, 2'b11, 2'b11) | slot_cfg(0, 2'b00, 2'b00, 2'b00));
    expect_access("R9 disarmed exec", 32'h1000, 2'b00, 2'b00, 1'b0, 4'h0);
  endtask

  task automatic t_multi_and_sticky();
    logic t0, t1, f;
    logic [AW-1:0] d;
    reg_write(3'd0, 32'h0000_5000);
    reg_write(3'd3, 32'h0000_5000);
    reg_write(3'd7, slot_cfg(0, 2'b01, 2'b00, 2'b00) | slot_cfg(3, 2'b11, 2'b00, 2'b00));
    expect_access("R7 two slots hit", 32'h5000, 2'b00, 2'b00, 1'b1, 4'h9);
    access(32'h6000, 2'b00, 2'b00, t0, t1);
    check("R8 miss no trap", AW'(t0), '0);
    reg_read(3'd6, d, f);
    check("R7 status sticky after miss", d, 32'h9);
    // Status clear and a match in the same cycle.
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_idx = 3'd6; reg_wdata = '0;
    mon_valid = 1'b1; mon_addr = 32'h5000; mon_size = 2'b00; mon_kind = 2'b00;
    @(posedge clk);
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0; mon_valid = 1'b0; mon_kind = 2'b11;
    check("R8 trap on collision", AW'(trap_o), 32'd1);
    reg_read(3'd6, d, f);
    check("R7 match wins over clear", d, 32'h9);
    reg_write(3'd6, 32'hFFFF_FFF2);
    reg_read(3'd6, d, f);
    check("R7 write replaces, upper zero", d, 32'h2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr_regs();
    t_alias();
    t_refused();
    t_exec();
    t_write_len2();
    t_rdwr_len4();
    t_disabled();
    t_multi_and_sticky();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule